// File: doc/BRIEF.md
# Dual-Edge Decade Counter

This block is a single-digit decimal up-counter for use inside a synchronous design. It watches two slow control lines, a count strobe and a gate, on a fast system clock. The count advances on either of two transitions: the strobe rising while the gate is high, or the gate falling while the strobe is low. Because the two lines can swap roles, a digit can be chained behind another. The next digit's gate takes the previous digit's most significant bit and its strobe is tied low. It then steps once each time the previous digit rolls over from nine to zero.

All three control lines (strobe, gate and a clear line) pass through a two-stage synchronizer before any edge is judged. A registered history of the synchronized strobe and gate gives the edges. The increment rule uses the levels of the newest synchronized sample. The digit is held as a 4-bit BCD value. A separate synchronous system reset puts the counter and the edge history into a known idle state.

Top module: `bcd_dual_edge_counter`

## Requirements
- R1: The output `digit` always holds a value from 0 to 9, with `digit[0]` the least significant bit. `carryMsb` always equals `digit[3]`.
- R2: A rising `cntStrobe` while `cntGate` is high (both as newly sampled) adds one to the count.
- R3: A falling `cntGate` while `cntStrobe` is low (both as newly sampled) adds one to the count.
- R4: A falling `cntStrobe` or a rising `cntGate` leaves the count unchanged.
- R5: A rising `cntStrobe` while `cntGate` is low leaves the count unchanged. So does a falling `cntGate` while `cntStrobe` is high.
- R6: An increment from 9 gives 0.
- R7: While `cntClear` is high, the count is forced to 0 and no edge changes it. Releasing `cntClear` does not itself change the count.
- R8: A change on an input that settles before a rising `sysClk` edge shows on `digit` just after the third rising `sysClk` edge from that point, and not before.
- R9: While `sysRst` is high at a rising `sysClk` edge, the count goes to 0 and the edge history goes to strobe low, gate low. After release, idle low inputs cause no step.
- R10: A second counter whose gate is driven by the first counter's `carryMsb`, with its strobe held low, steps exactly once per 9-to-0 rollover of the first counter.
- R11: When `cntStrobe` rises and `cntGate` falls in the same sample, the count does not change. The count never moves by more than one per system cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sysClk | input | 1 | System clock |
| sysRst | input | 1 | Synchronous reset, active high |
| cntStrobe | input | 1 | Asynchronous count strobe |
| cntGate | input | 1 | Asynchronous count gate, interchangeable with the strobe |
| cntClear | input | 1 | Asynchronous clear, active high |
| digit | output | 4 | BCD count value |
| carryMsb | output | 1 | Most significant count bit, for chaining into the next digit's gate |

## Verification
The hardest case to reach from the ports is a chained digit stepping only on the rollover of its neighbour. The rising and falling MSB at 7-to-8 and 9-to-0 pass through a second synchronizer, three cycles behind the first digit. The bench builds a two-digit chain and drives every ordered pair of strobe and gate levels several times over, which covers all sixteen input transitions. It waits out both pipeline delays before comparing each digit with an arithmetic model. It also drives a simultaneous strobe rise and gate fall, a clear that arrives together with a qualifying edge, and single-cycle latency probes.

// File: rtl/bcd_counter_pkg.sv
package bcd_counter_pkg;
  typedef struct packed {
    logic step;
    logic clear;
  } cnt_strobes_t;
endpackage

// File: rtl/bcd_input_sync.sv
module bcd_input_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             sysClk,
  input  logic             sysRst,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  localparam int LastStage = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge sysClk) begin
      if (sysRst) chain <= '0;
      else        chain <= {chain[STAGES-2:0], asyncIn[b]};
    end
    assign syncOut[b] = chain[LastStage];
  end
endmodule

// File: rtl/bcd_edge_ctrl.sv
module bcd_edge_ctrl
  import bcd_counter_pkg::*;
(
  input  logic         sysClk,
  input  logic         sysRst,
  input  logic         strobeSync,
  input  logic         gateSync,
  input  logic         clearSync,
  output cnt_strobes_t ctl
);
  logic strobePrev, gatePrev;
  logic strobeRise, gateFall, advance;

  always_ff @(posedge sysClk) begin
    if (sysRst) begin
      strobePrev <= 1'b0;
      gatePrev   <= 1'b0;
    end else begin
      strobePrev <= strobeSync;
      gatePrev   <= gateSync;
    end
  end

  always_comb begin
    strobeRise = strobeSync & ~strobePrev;
    gateFall   = ~gateSync & gatePrev;
    advance    = (strobeRise & gateSync) | (gateFall & ~strobeSync);
    ctl.clear  = clearSync;
    ctl.step   = advance & ~clearSync;
  end
endmodule

// File: rtl/bcd_digit_path.sv
module bcd_digit_path
  import bcd_counter_pkg::*;
#(
  parameter int DIGIT_W    = 4,
  parameter int LAST_DIGIT = 9
) (
  input  logic               sysClk,
  input  logic               sysRst,
  input  cnt_strobes_t       ctl,
  output logic [DIGIT_W-1:0] count
);
  localparam logic [DIGIT_W-1:0] LastVal = LAST_DIGIT[DIGIT_W-1:0];

  always_ff @(posedge sysClk) begin
    if (sysRst || ctl.clear)  count <= '0;
    else if (ctl.step) begin
      if (count >= LastVal)   count <= '0;
      else                    count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/bcd_dual_edge_counter.sv
module bcd_dual_edge_counter
  import bcd_counter_pkg::*;
#(
  parameter int DIGIT_W     = 4,
  parameter int LAST_DIGIT  = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic               sysClk,
  input  logic               sysRst,
  input  logic               cntStrobe,
  input  logic               cntGate,
  input  logic               cntClear,
  output logic [DIGIT_W-1:0] digit,
  output logic               carryMsb
);
  localparam int NumCtl = 3;

  logic [NumCtl-1:0] rawIn, syncIn;
  cnt_strobes_t      ctl;

  assign rawIn = {cntClear, cntGate, cntStrobe};

  bcd_input_sync #(.WIDTH(NumCtl), .STAGES(SYNC_STAGES)) u_sync (
    .sysClk (sysClk),
    .sysRst (sysRst),
    .asyncIn(rawIn),
    .syncOut(syncIn)
  );

  bcd_edge_ctrl u_ctrl (
    .sysClk    (sysClk),
    .sysRst    (sysRst),
    .strobeSync(syncIn[0]),
    .gateSync  (syncIn[1]),
    .clearSync (syncIn[2]),
    .ctl       (ctl)
  );

  bcd_digit_path #(.DIGIT_W(DIGIT_W), .LAST_DIGIT(LAST_DIGIT)) u_path (
    .sysClk(sysClk),
    .sysRst(sysRst),
    .ctl   (ctl),
    .count (digit)
  );

  assign carryMsb = digit[DIGIT_W-1];
endmodule

// File: rtl/bcd_counter_checker.sv
module bcd_counter_checker
  import bcd_counter_pkg::*;
#(
  parameter int DIGIT_W    = 4,
  parameter int LAST_DIGIT = 9
) (
  input logic               sysClk,
  input logic               sysRst,
  input cnt_strobes_t       ctl,
  input logic [DIGIT_W-1:0] digit
);
  localparam logic [DIGIT_W-1:0] LastVal = LAST_DIGIT[DIGIT_W-1:0];

  // R1: the digit never leaves the decimal range
  a_r1_in_range: assert property (@(posedge sysClk) disable iff (sysRst)
    digit <= LastVal);

  // R2 / R3: a step below the last value adds exactly one
  a_r2_step_adds_one: assert property (@(posedge sysClk) disable iff (sysRst)
    (ctl.step && !ctl.clear && digit < LastVal) |=> digit == $past(digit) + 1'b1);

  // R6: a step at the last value returns to zero
  a_r6_wrap: assert property (@(posedge sysClk) disable iff (sysRst)
    (ctl.step && !ctl.clear && digit == LastVal) |=> digit == '0);

  // R4 / R5: no strobe, no change
  a_r4_hold: assert property (@(posedge sysClk) disable iff (sysRst)
    (!ctl.step && !ctl.clear) |=> $stable(digit));

  // R7: clear forces zero
  a_r7_clear: assert property (@(posedge sysClk) disable iff (sysRst)
    ctl.clear |=> digit == '0);

  // R7: a clear request never coexists with a step request
  a_r7_clear_wins: assert property (@(posedge sysClk) disable iff (sysRst)
    ctl.clear |-> !ctl.step);
endmodule

bind bcd_dual_edge_counter bcd_counter_checker #(
  .DIGIT_W(DIGIT_W), .LAST_DIGIT(LAST_DIGIT)
) u_checker (
  .sysClk(sysClk),
  .sysRst(sysRst),
  .ctl   (ctl),
  .digit (digit)
);

// File: tb/tb_bcd_dual_edge_counter.sv
`timescale 1ns/1ps
module tb_bcd_dual_edge_counter;
  logic sysClk = 1'b0;
  logic sysRst = 1'b1;
  logic cntStrobe = 1'b0, cntGate = 1'b0, cntClear = 1'b0;
  logic [3:0] digit, digit2;
  logic carryMsb, carryMsb2;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int exp1 = 0, exp2 = 0;
  logic curS = 1'b0, curG = 1'b0;

  always #2 sysClk = ~sysClk;

  bcd_dual_edge_counter dut (
    .sysClk(sysClk), .sysRst(sysRst), .cntStrobe(cntStrobe), .cntGate(cntGate),
    .cntClear(cntClear), .digit(digit), .carryMsb(carryMsb)
  );

  bcd_dual_edge_counter dut2 (
    .sysClk(sysClk), .sysRst(sysRst), .cntStrobe(1'b0), .cntGate(carryMsb),
    .cntClear(cntClear), .digit(digit2), .carryMsb(carryMsb2)
  );

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge sysClk);
  endtask

  function automatic bit qualifies(logic os, logic og, logic ns, logic ng);
    return ((ns & ~os) & ng) | ((~ng & og) & ~ns);
  endfunction

  task automatic bump();
    if (exp1 == 9) begin
      exp1 = 0;
      exp2 = (exp2 == 9) ? 0 : exp2 + 1;
    end else exp1 = exp1 + 1;
  endtask

  task automatic apply(input logic ns, input logic ng, input string req);
    bit wrapCase;
    wrapCase = (exp1 == 9);
    cntStrobe = ns;
    cntGate   = ng;
    if (qualifies(curS, curG, ns, ng)) bump();
    curS = ns;
    curG = ng;
    cycles(8);
    chk(req, digit, exp1);
    chk("R1", carryMsb, exp1 / 8);
    chk("R10", digit2, exp2);
    if (wrapCase) chk("R6", digit, exp1);
  endtask

  function automatic string tagFor(logic os, logic og, logic ns, logic ng);
    if (ns && !os && ng) return "R2";
    if (!ng && og && !ns) return "R3";
    if (ns && !os && !ng && og) return "R11";
    if (ns && !os) return "R5";
    if (!ng && og) return "R5";
    return "R4";
  endfunction

  initial begin
    cycles(3);
    sysRst = 1'b0;
    cycles(2);
    chk("R9", digit, 0);
    chk("R1", carryMsb, 0);

    // sweep all ordered level pairs
    for (int rep = 0; rep < 4; rep++)
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++) begin
          apply(a[1], a[0], tagFor(curS, curG, a[1], a[0]));
          apply(b[1], b[0], tagFor(curS, curG, b[1], b[0]));
        end

    // R11: strobe rises while gate falls in one sample
    apply(1'b0, 1'b1, "R4");
    apply(1'b1, 1'b0, "R11");

    // R8: latency probe on a strobe rise with gate high
    apply(1'b0, 1'b1, "R4");
    cntStrobe = 1'b1;
    curS = 1'b1;
    @(posedge sysClk); @(posedge sysClk); @(negedge sysClk);
    chk("R8", digit, exp1);
    bump();
    @(negedge sysClk);
    chk("R8", digit, exp1);
    cycles(6);
    chk("R10", digit2, exp2);

    // R7: clear together with a qualifying edge
    apply(1'b0, 1'b1, "R4");
    if (exp1 == 0) apply(1'b1, 1'b1, "R2");
    cntClear = 1'b1;
    cntStrobe = 1'b1;
    curS = 1'b1;
    exp1 = 0;
    exp2 = 0;
    cycles(8);
    chk("R7", digit, 0);
    chk("R7", digit2, 0);
    cntClear = 1'b0;
    cycles(8);
    chk("R7", digit, 0);
    apply(1'b0, 1'b1, "R4");
    apply(1'b1, 1'b1, "R2");

    // R9: system reset with idle inputs
    cntStrobe = 1'b0;
    cntGate = 1'b0;
    cycles(4);
    sysRst = 1'b1;
    cycles(2);
    sysRst = 1'b0;
    curS = 1'b0;
    curG = 1'b0;
    exp1 = 0;
    exp2 = 0;
    cycles(8);
    chk("R9", digit, 0);
    chk("R9", digit2, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule